// File: doc/BRIEF.md
# Host Register Port for a Video Encoder

This block connects an 8-bit microprocessor port to the configuration state of a video encoder. The port uses an active-low chip select, active-low read and write strobes, and a register-select line. All of these pins are sampled asynchronously. They pass through a synchronizer into the pixel clock domain, and every access acts on the falling edge of its strobe as seen after synchronization.

With register-select low, an access reaches a pointer register. With register-select high, it reaches whatever the pointer names:
- one of seven command registers, each with a fixed default;
- an entry of a sixteen-colour palette, moved as three bytes in a row on one pointer value;
- a reserved hole.

The video pipeline reads the palette through a separate index port. It also receives the command registers as a flat vector and the horizontal blanking offset already decoded to a signed number.

Two other functions live here:
- **Strap mode.** Holding all three control strobes low turns the port into a set of static strap inputs, for systems that have no host.
- **Reset.** A reset pin with a stretched release drives the block reset, which this block also hands to the rest of the encoder.

Top module: `host_reg_port`

## Requirements
- R1: With `regSel` low, a write strobe loads `busIn` into the pointer register, and a read strobe returns the pointer on `busOut`.
- R2: After reset the seven command registers at pointers 00h to 06h hold 02h, 01h, 00h, 00h, 00h, 00h, 00h. `cmdFlat[8*k+7:8*k]` is register k. Any number of data writes and reads may follow one pointer write to the same register.
- R3: A palette entry (pointer 10h + index) is written and read as three data strobes in the order luma, red-difference, blue-difference. Luma keeps bits 7:2 and clears bits 1:0. Both colour components keep bits 7:3 and clear bits 2:0. `palColor` shows the entry selected by `palIdx` as {luma, red-diff, blue-diff}. Palette contents survive reset.
- R4: The palette byte position returns to luma on every pointer write and every rise of chip select.
- R5: Data writes at pointers 07h to 0Fh and 20h to FFh change no register, and data reads there return 00h.
- R6: `busOe` is high only while both synchronized chip select and read are low. It is low for as long as chip select is high.
- R7: A data write to pointer 00h with bit 7 set puts all seven command registers back to their defaults, and bit 7 does not stay set.
- R8: When chip select, read and write are all held low for three clocks after synchronization, `strapMode` rises. While it is high, `strapComposite` follows bus bit 7, `strapColorBar` follows bus bit 6, `strapSel` follows `regSel`, and the bus is not driven. Two clocks of all-low are not enough. Raising any strobe leaves strap mode.
- R9: `coreReset` goes high as soon as `rstPinN` goes low. It stays high through the fifth rising clock edge after `rstPinN` returns high and is low after that edge.
- R10: `hblankOffset` decodes bits 4:0 of register 05h as sign-magnitude: bit 4 set means negative, and bits 3:0 are the size. 00011 gives +3, 10011 gives -3, 01111 gives +15 and 11111 gives -15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstPinN | input | 1 | Reset pin, active low |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| regSel | input | 1 | Low: pointer register; high: register named by the pointer |
| busIn | input | 8 | Data bus, inbound half |
| busOut | output | 8 | Data bus, outbound half |
| busOe | output | 1 | Drive enable for the outbound half |
| palIdx | input | 4 | Palette index from the video pipeline |
| palColor | output | 24 | Selected palette entry {luma, red-diff, blue-diff} |
| cmdFlat | output | 56 | The seven command registers, register 0 in the low byte |
| hblankOffset | output | 6 | Signed horizontal blanking offset in clocks |
| coreReset | output | 1 | Stretched block reset, active high |
| strapMode | output | 1 | Strap mode active |
| strapSel | output | 1 | Strap value from `regSel` |
| strapComposite | output | 1 | Strap value from bus bit 7 (composite versus separate luma/chroma) |
| strapColorBar | output | 1 | Strap value from bus bit 6 (colour bar enable) |

## Verification
The bench builds the block with its default parameters:
- two synchronizer stages;
- a five-clock reset release;
- a three-clock strap window.

With these values, the exact release edge of the reset and the two-versus-three clock strap boundary can be checked at cycle level. Random pointer and data traffic is compared against a model of the command registers and the palette, covering both masks and the pointer wrap into the palette window. Directed cases cover:
- an interrupted palette triple;
- reserved holes;
- the software reset bit;
- the edges of the blanking offset decode.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_CMD   = 7;
  localparam int PAL_DEPTH = 16;
  localparam int PAL_BASE  = 16;
  localparam int HVT_ADDR  = 5;
  localparam logic [7:0] Y_MASK = 8'hFC;
  localparam logic [7:0] C_MASK = 8'hF8;

  typedef struct packed {
    logic              wrAddr;
    logic              wrReg;
    logic              rdAddr;
    logic              rdReg;
    logic              csRelease;
    logic [DATA_W-1:0] data;
  } hrpStrobe_t;

  function automatic logic [DATA_W-1:0] cmdDefault(input int idx);
    case (idx)
      0:       return 8'h02;
      1:       return 8'h01;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
  import hrp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD    = 5,
  parameter int STRAP_CLKS  = 3
) (
  input  logic        clk,
  input  logic        rstPinN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        regSel,
  input  logic [7:0]  busIn,
  output hrpStrobe_t  strobe,
  output logic        coreReset,
  output logic        busOe,
  output logic        strapMode,
  output logic        strapSel,
  output logic        strapComposite,
  output logic        strapColorBar
);
  localparam int SW  = 4 + DATA_W;
  localparam int RCW = $clog2(RST_HOLD + 1);
  localparam int SCW = $clog2(STRAP_CLKS + 1);
  localparam logic [SW-1:0] IDLE = {3'b111, 1'b0, {DATA_W{1'b0}}};

  // reset stretcher: asynchronous assert, counted release
  logic [RCW-1:0] relCnt;
  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      coreReset <= 1'b1;
      relCnt    <= '0;
    end else if (coreReset) begin
      if (relCnt == RCW'(RST_HOLD - 1)) coreReset <= 1'b0;
      else                              relCnt    <= relCnt + 1'b1;
    end
  end

  // synchronizer chain over all host pins
  logic [SW-1:0] syncQ [SYNC_STAGES];
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (coreReset) syncQ[s] <= IDLE;
      else if (s == 0) syncQ[s] <= {csN, rdN, wrN, regSel, busIn};
      else             syncQ[s] <= syncQ[s-1];
    end
  end

  logic       csS, rdS, wrS, selS;
  logic [7:0] dataS;
  assign {csS, rdS, wrS, selS, dataS} = syncQ[SYNC_STAGES-1];

  logic csP, rdP, wrP;
  always_ff @(posedge clk) begin
    if (coreReset) {csP, rdP, wrP} <= 3'b111;
    else           {csP, rdP, wrP} <= {csS, rdS, wrS};
  end

  // strap detection
  logic           allLow;
  logic [SCW-1:0] strapCnt;
  assign allLow = ~csS & ~rdS & ~wrS;
  always_ff @(posedge clk) begin
    if (coreReset || !allLow) begin
      strapCnt  <= '0;
      strapMode <= 1'b0;
    end else if (strapCnt == SCW'(STRAP_CLKS - 1)) begin
      strapMode <= 1'b1;
    end else begin
      strapCnt <= strapCnt + 1'b1;
    end
  end

  logic active, wrFall, rdFall;
  assign active = ~coreReset & ~strapMode & ~csS;
  assign wrFall = wrP & ~wrS;
  assign rdFall = rdP & ~rdS;

  always_comb begin
    strobe.wrAddr    = active & wrFall & ~selS;
    strobe.wrReg     = active & wrFall &  selS;
    strobe.rdAddr    = active & rdFall & ~selS;
    strobe.rdReg     = active & rdFall &  selS;
    strobe.csRelease = ~csP & csS;
    strobe.data      = dataS;
  end

  assign busOe          = ~coreReset & ~strapMode & ~csS & ~rdS;
  assign strapSel       = strapMode & selS;
  assign strapComposite = strapMode & dataS[7];
  assign strapColorBar  = strapMode & dataS[6];
endmodule

// File: rtl/hrp_datapath.sv
module hrp_datapath
  import hrp_pkg::*;
(
  input  logic                      clk,
  input  logic                      coreReset,
  input  hrpStrobe_t                strobe,
  input  logic [3:0]                palIdx,
  output logic [7:0]                busOut,
  output logic [7:0]                curAddr,
  output logic [NUM_CMD*DATA_W-1:0] cmdFlat,
  output logic [23:0]               palColor,
  output logic signed [5:0]         hblankOffset
);
  localparam int CMD_AW = $clog2(NUM_CMD);
  localparam int PAL_AW = $clog2(PAL_DEPTH);

  logic [7:0]        addrReg;
  logic [1:0]        bytePos;
  logic [7:0]        cmdReg [NUM_CMD];
  logic [7:0]        palY   [PAL_DEPTH];
  logic [7:0]        palCr  [PAL_DEPTH];
  logic [7:0]        palCb  [PAL_DEPTH];
  logic              isCmd, isPal, swReset;
  logic [PAL_AW-1:0] palSlot;
  logic [7:0]        readByte;

  assign isCmd   = addrReg < 8'(NUM_CMD);
  assign isPal   = (addrReg >= 8'(PAL_BASE)) && (addrReg < 8'(PAL_BASE + PAL_DEPTH));
  assign palSlot = addrReg[PAL_AW-1:0];
  assign swReset = strobe.wrReg && (addrReg == 8'd0) && strobe.data[7];
  assign curAddr = addrReg;

  always_ff @(posedge clk) begin
    if (coreReset)          addrReg <= '0;
    else if (strobe.wrAddr) addrReg <= strobe.data;
  end

  always_ff @(posedge clk) begin
    if (coreReset || strobe.wrAddr || strobe.csRelease || swReset)
      bytePos <= '0;
    else if ((strobe.wrReg || strobe.rdReg) && isPal)
      bytePos <= (bytePos == 2'd2) ? 2'd0 : bytePos + 1'b1;
  end

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    always_ff @(posedge clk) begin
      if (coreReset || swReset)
        cmdReg[g] <= cmdDefault(g);
      else if (strobe.wrReg && addrReg == 8'(g))
        cmdReg[g] <= strobe.data;
    end
    assign cmdFlat[g*DATA_W +: DATA_W] = cmdReg[g];
  end

  always_ff @(posedge clk) begin
    if (!coreReset && strobe.wrReg && isPal) begin
      case (bytePos)
        2'd0:    palY[palSlot]  <= strobe.data & Y_MASK;
        2'd1:    palCr[palSlot] <= strobe.data & C_MASK;
        default: palCb[palSlot] <= strobe.data & C_MASK;
      endcase
    end
  end

  always_comb begin
    readByte = 8'h00;
    if (isCmd) readByte = cmdReg[addrReg[CMD_AW-1:0]];
    else if (isPal) begin
      case (bytePos)
        2'd0:    readByte = palY[palSlot];
        2'd1:    readByte = palCr[palSlot];
        default: readByte = palCb[palSlot];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (coreReset)         busOut <= '0;
    else if (strobe.rdAddr) busOut <= addrReg;
    else if (strobe.rdReg)  busOut <= readByte;
  end

  assign palColor = {palY[palIdx], palCr[palIdx], palCb[palIdx]};

  logic [4:0]        hbField;
  logic signed [5:0] hbMag;
  assign hbField      = cmdReg[HVT_ADDR][4:0];
  assign hbMag        = $signed({2'b00, hbField[3:0]});
  assign hblankOffset = hbField[4] ? -hbMag : hbMag;
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import hrp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD    = 5,
  parameter int STRAP_CLKS  = 3
) (
  input  logic        clk,
  input  logic        rstPinN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        regSel,
  input  logic [7:0]  busIn,
  output logic [7:0]  busOut,
  output logic        busOe,
  input  logic [3:0]  palIdx,
  output logic [23:0] palColor,
  output logic [55:0] cmdFlat,
  output logic [5:0]  hblankOffset,
  output logic        coreReset,
  output logic        strapMode,
  output logic        strapSel,
  output logic        strapComposite,
  output logic        strapColorBar
);
  hrpStrobe_t strobe;
  logic [7:0] curAddr;

  hrp_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .RST_HOLD(RST_HOLD), .STRAP_CLKS(STRAP_CLKS)
  ) i_ctrl (
    .clk(clk), .rstPinN(rstPinN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .regSel(regSel), .busIn(busIn), .strobe(strobe), .coreReset(coreReset),
    .busOe(busOe), .strapMode(strapMode), .strapSel(strapSel),
    .strapComposite(strapComposite), .strapColorBar(strapColorBar)
  );

  hrp_datapath i_data (
    .clk(clk), .coreReset(coreReset), .strobe(strobe), .palIdx(palIdx),
    .busOut(busOut), .curAddr(curAddr), .cmdFlat(cmdFlat),
    .palColor(palColor), .hblankOffset(hblankOffset)
  );
endmodule

// File: rtl/hrp_checker.sv
module hrp_checker
  import hrp_pkg::*;
#(
  parameter int RST_HOLD = 5
) (
  input logic        clk,
  input logic        rstPinN,
  input logic        csN,
  input logic        busOe,
  input logic        coreReset,
  input logic        strapMode,
  input hrpStrobe_t  strobe,
  input logic [7:0]  curAddr,
  input logic [55:0] cmdFlat
);
  logic [7:0] hiCnt;
  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN)            hiCnt <= '0;
    else if (hiCnt != 8'hFF) hiCnt <= hiCnt + 1'b1;
  end

  // R9
  reset_release_chk: assert property (@(posedge clk) disable iff (!rstPinN)
    $fell(coreReset) |-> hiCnt == 8'(RST_HOLD));

  // R6
  bus_idle_chk: assert property (@(posedge clk) disable iff (coreReset)
    $past(csN, 2) |-> !busOe);

  // R5
  reserved_write_chk: assert property (@(posedge clk) disable iff (coreReset)
    (strobe.wrReg && ((curAddr >= 8'h07 && curAddr < 8'h10) || curAddr >= 8'h20))
    |=> $stable(cmdFlat));

  // R7
  soft_reset_chk: assert property (@(posedge clk) disable iff (coreReset)
    (strobe.wrReg && curAddr == 8'h00 && strobe.data[7])
    |=> cmdFlat == 56'h00_0000_0000_0102);

  // R8
  strap_entry_chk: assert property (@(posedge clk) disable iff (coreReset)
    $rose(strapMode) |-> (!$past(csN, 3) && !$past(csN, 4) && !$past(csN, 5)));
endmodule

bind host_reg_port hrp_checker #(.RST_HOLD(RST_HOLD)) i_hrpChk (
  .clk(clk), .rstPinN(rstPinN), .csN(csN), .busOe(busOe),
  .coreReset(coreReset), .strapMode(strapMode), .strobe(strobe),
  .curAddr(curAddr), .cmdFlat(cmdFlat)
);

// File: tb/test_host_reg_port.sv
`timescale 1ns/1ps
module test_host_reg_port;
  logic        clk = 1'b0;
  logic        rstPinN = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, wrN = 1'b1, regSel = 1'b0;
  logic [7:0]  busIn = 8'h00;
  logic [3:0]  palIdx = 4'h0;
  logic [7:0]  busOut;
  logic        busOe;
  logic [23:0] palColor;
  logic [55:0] cmdFlat;
  logic [5:0]  hblankOffset;
  logic        coreReset, strapMode, strapSel, strapComposite, strapColorBar;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] cmdModel [7];
  logic [7:0] pyM [16];
  logic [7:0] prM [16];
  logic [7:0] pbM [16];

  always #2.5 clk = ~clk;

  host_reg_port i_host_reg_port (
    .clk(clk), .rstPinN(rstPinN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .regSel(regSel), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .palIdx(palIdx), .palColor(palColor), .cmdFlat(cmdFlat),
    .hblankOffset(hblankOffset), .coreReset(coreReset),
    .strapMode(strapMode), .strapSel(strapSel),
    .strapComposite(strapComposite), .strapColorBar(strapColorBar)
  );

  function automatic logic [55:0] modelFlat();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[k*8 +: 8] = cmdModel[k];
    return v;
  endfunction

  function automatic void modelDefaults();
    for (int k = 0; k < 7; k++) cmdModel[k] = 8'h00;
    cmdModel[0] = 8'h02;
    cmdModel[1] = 8'h01;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [7:0] d);
    regSel = sel; busIn = d; tick(1);
    wrN = 1'b0; tick(4);
    wrN = 1'b1; tick(4);
  endtask

  task automatic hostRead(input logic sel, output logic [7:0] d);
    regSel = sel; tick(1);
    rdN = 1'b0; tick(4);
    d = busOut;
    rdN = 1'b1; tick(4);
  endtask

  task automatic csLow();  csN = 1'b0; tick(3); endtask
  task automatic csHigh(); csN = 1'b1; tick(4); endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd4242));
    modelDefaults();
    tick(8);
    chk("R9 reset held", 64'(coreReset), 64'd1);
    chk("R6 oe in reset", 64'(busOe), 64'd0);
    rstPinN = 1'b1;
    tick(4);
    chk("R9 reset still high after 4 edges", 64'(coreReset), 64'd1);
    tick(1);
    chk("R9 reset low after 5th edge", 64'(coreReset), 64'd0);
    chk("R2 defaults", 64'(cmdFlat), 64'(modelFlat()));

    rdN = 1'b0; tick(4);
    chk("R6 oe with cs high", 64'(busOe), 64'd0);
    rdN = 1'b1; tick(3);

    csLow();
    hostWrite(1'b0, 8'h05);
    regSel = 1'b0; tick(1); rdN = 1'b0; tick(4);
    chk("R6 oe during read", 64'(busOe), 64'd1);
    chk("R1 pointer readback", 64'(busOut), 64'h05);
    rdN = 1'b1; tick(4);

    // R10 blanking offset decode, repeated writes on one pointer (R2)
    hostWrite(1'b1, 8'h03); chk("R10 +3", 64'(hblankOffset), 64'h03);
    hostWrite(1'b1, 8'h13); chk("R10 -3", 64'(hblankOffset), 64'h3D);
    hostWrite(1'b1, 8'h0F); chk("R10 +15", 64'(hblankOffset), 64'h0F);
    hostWrite(1'b1, 8'h1F); chk("R10 -15", 64'(hblankOffset), 64'h31);
    cmdModel[5] = 8'h1F;
    hostRead(1'b1, rd); chk("R2 repeat read", 64'(rd), 64'h1F);

    for (int i = 0; i < 20; i++) begin
      logic [7:0] a, d;
      a = 8'(1 + ($urandom % 6));
      d = 8'($urandom);
      hostWrite(1'b0, a);
      hostWrite(1'b1, d);
      cmdModel[a] = d;
      hostRead(1'b1, rd);
      chk("R2 random readback", 64'(rd), 64'(d));
    end
    chk("R2 flat vector", 64'(cmdFlat), 64'(modelFlat()));

    hostWrite(1'b0, 8'h0A); hostWrite(1'b1, 8'h5A);
    hostRead(1'b1, rd);
    chk("R5 reserved read 0Ah", 64'(rd), 64'h00);
    hostWrite(1'b0, 8'h40); hostWrite(1'b1, 8'hA5);
    hostRead(1'b1, rd);
    chk("R5 reserved read 40h", 64'(rd), 64'h00);
    chk("R5 registers untouched", 64'(cmdFlat), 64'(modelFlat()));

    for (int i = 0; i < 6; i++) begin
      logic [3:0] idx;
      logic [7:0] y, r, b;
      idx = 4'($urandom); y = 8'($urandom); r = 8'($urandom); b = 8'($urandom);
      hostWrite(1'b0, 8'h10 + 8'(idx));
      hostWrite(1'b1, y); hostWrite(1'b1, r); hostWrite(1'b1, b);
      pyM[idx] = y & 8'hFC; prM[idx] = r & 8'hF8; pbM[idx] = b & 8'hF8;
      palIdx = idx; tick(1);
      chk("R3 palette port", 64'(palColor), 64'({pyM[idx], prM[idx], pbM[idx]}));
      hostWrite(1'b0, 8'h10 + 8'(idx));
      hostRead(1'b1, rd); chk("R3 read luma", 64'(rd), 64'(pyM[idx]));
      hostRead(1'b1, rd); chk("R3 read red-diff", 64'(rd), 64'(prM[idx]));
      hostRead(1'b1, rd); chk("R3 read blue-diff", 64'(rd), 64'(pbM[idx]));
    end

    // R4 restart on chip-select rise
    hostWrite(1'b0, 8'h12);
    hostWrite(1'b1, 8'h11);
    csHigh(); csLow();
    hostWrite(1'b1, 8'hE4); hostWrite(1'b1, 8'h7F); hostWrite(1'b1, 8'h3C);
    palIdx = 4'h2; tick(1);
    chk("R4 restart after cs rise", 64'(palColor), 64'h E4_78_38);
    // R4 restart on pointer write
    hostWrite(1'b0, 8'h13);
    hostWrite(1'b1, 8'h55); hostWrite(1'b1, 8'h66);
    hostWrite(1'b0, 8'h13);
    hostWrite(1'b1, 8'hAB); hostWrite(1'b1, 8'hCD); hostWrite(1'b1, 8'hEF);
    palIdx = 4'h3; tick(1);
    chk("R4 restart after pointer write", 64'(palColor), 64'h A8_C8_E8);

    // R7 software reset
    hostWrite(1'b0, 8'h00);
    hostWrite(1'b1, 8'h8C);
    modelDefaults();
    chk("R7 defaults restored", 64'(cmdFlat), 64'(modelFlat()));
    hostRead(1'b1, rd);
    chk("R7 bit 7 clear", 64'(rd), 64'h02);
    csHigh();

    // R8 strap mode
    regSel = 1'b1; busIn = 8'hC0; tick(1);
    csN = 1'b0; rdN = 1'b0; wrN = 1'b0; tick(2);
    csN = 1'b1; rdN = 1'b1; wrN = 1'b1; tick(4);
    chk("R8 two clocks not enough", 64'(strapMode), 64'd0);
    csN = 1'b0; rdN = 1'b0; wrN = 1'b0; tick(6);
    chk("R8 strap entered", 64'(strapMode), 64'd1);
    chk("R8 composite from bit 7", 64'(strapComposite), 64'd1);
    chk("R8 colour bar from bit 6", 64'(strapColorBar), 64'd1);
    chk("R8 select strap", 64'(strapSel), 64'd1);
    chk("R8 bus not driven", 64'(busOe), 64'd0);
    busIn = 8'h40; regSel = 1'b0; tick(4);
    chk("R8 composite follows", 64'(strapComposite), 64'd0);
    chk("R8 colour bar follows", 64'(strapColorBar), 64'd1);
    chk("R8 select follows", 64'(strapSel), 64'd0);
    rdN = 1'b1; tick(5);
    chk("R8 strap left", 64'(strapMode), 64'd0);
    csN = 1'b1; wrN = 1'b1; tick(4);

    finishRun();
  end
endmodule